// File: doc/BRIEF.md
# Interrupt Routing Multiplexer

This block steers 32 level-sensitive interrupt sources onto a bank of up to 15 interrupt output lines. Every source carries its own 4-bit route code, held in software-writable registers. A code of zero parks the source, so it reaches no output. A non-zero code v sends the source to output line v−1. Each output line is the OR of every enabled, asserted source whose code selects it. The routing can be rewritten at any time while the system runs.

Output lines 0 to 5 are hard-wired onto an 8-bit CPU interrupt bus at bit positions 2 to 7. Route code n therefore raises CPU line n+1, and codes 7 to 15 drive only the wider output bank. CPU bus bits 0 and 1 stay low. A per-source enable mask gates each input. A read-only word reflects the raw input levels. Software reaches all of these through a plain single-cycle word port: writes land at the next clock edge and reads return the current contents combinationally. The output lines are registered.

Top module: `irq_router`

## Requirements
- R1: After reset every route word and the mask word read as zero, and all output lines and the CPU bus are low.
- R2: Source i's route code lives in route word i/8 (word addresses 0 to 3), at bits 4·(i mod 8) up to 4·(i mod 8)+3, and a written route or mask word reads back unchanged.
- R3: A route code of 0 keeps its source off every output line, whatever its level.
- R4: A route code v in 1..15 connects its source to output line v−1 and to no other line.
- R5: Each output line is the logical OR of all enabled, asserted sources routed to it, including after the routing is rewritten at run time.
- R6: The mask word (address 4) enables source i through bit i (1 = enabled); a masked source affects no output.
- R7: CPU bus bit k, for k in 2..7, equals output line k−2; bits 0 and 1 are always low, so codes 7 to 15 reach no CPU line.
- R8: Address 5 returns the raw source levels regardless of mask and routing, and writes to it change nothing.
- R9: Output lines change exactly one clock edge after the inputs or routing that produce them, and not before.
- R10: Addresses 6 and 7 read as zero, and writes to them alter no route word, the mask or any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_irq | input | 32 | Level interrupt sources, bit i is source i |
| reg_addr | input | 3 | Word address of the register port |
| reg_we | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word, combinational |
| out_line | output | 15 | Registered output lines, bit o is line o |
| cpu_irq | output | 8 | CPU interrupt bus, bits 2..7 carry output lines 0..5 |

## Verification
On every cycle the assertions compare the output lines with a reference computed from the previous cycle's sources, mask and route words. They also check that masked-off traffic leaves the outputs quiet, that the CPU bus mirrors lines 0 to 5 with its two low bits clear, and that the status and unmapped addresses read as specified. What the assertions cannot show is that the route codes sit at the right bit positions of the right words, that a write takes effect at the intended edge, or that writes to status and unmapped addresses leave the state alone. The bench shows these by sweeping every source against every code, reading words back after writes, and running pseudo-random mask, source and rerouting patterns against an arithmetic model.

// File: rtl/irq_router_pkg.sv
// Package: irq_router_pkg
// Shared constants for the interrupt routing multiplexer: default sizes
// and the word address map of the register port.
// Assumes one mask bit per source, so the source count equals the data width.
package irq_router_pkg;

    // Default register data width; also the number of sources.
    localparam int DEF_DATA_W    = 32;
    // Width of one route code.
    localparam int DEF_FIELD_W   = 4;
    // Width of the CPU interrupt bus.
    localparam int DEF_CPU_BUS_W = 8;
    // First CPU bus bit driven by output line 0.
    localparam int DEF_CPU_BASE  = 2;
    // Number of output lines wired onto the CPU bus.
    localparam int DEF_CPU_LINES = 6;
    // Register port address width.
    localparam int ADDR_W        = 3;

    // Kind of word selected by an address.
    typedef enum logic [1:0] {
        WORD_ROUTE  = 2'd0,
        WORD_MASK   = 2'd1,
        WORD_STATUS = 2'd2,
        WORD_NONE   = 2'd3
    } word_kind_e;

endpackage

// File: rtl/irq_router_regs.sv
// Module: irq_router_regs
// Holds the route words and the mask word and serves the register port.
// Route words take the lowest addresses, the mask follows, then the
// read-only status word; anything above reads zero and ignores writes.
// Assumes reg_we is sampled once per clock; reads are combinational.
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int ROUTE_REGS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [DATA_W-1:0]              src_irq,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic                           reg_we,
    input  logic [DATA_W-1:0]              reg_wdata,
    output logic [DATA_W-1:0]              reg_rdata,
    output logic [ROUTE_REGS*DATA_W-1:0]   route_flat,
    output logic [DATA_W-1:0]              src_en
);

    localparam int RIDX_W = (ROUTE_REGS > 1) ? $clog2(ROUTE_REGS) : 1;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = ADDR_W'(ROUTE_REGS);
    localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(ROUTE_REGS + 1);

    logic [DATA_W-1:0] route_q [ROUTE_REGS];
    logic [DATA_W-1:0] mask_q;
    word_kind_e        kind;
    logic [RIDX_W-1:0] ridx;

    // Classify the current address.
    always_comb begin
        if (reg_addr < ADDR_MASK)         kind = WORD_ROUTE;
        else if (reg_addr == ADDR_MASK)   kind = WORD_MASK;
        else if (reg_addr == ADDR_STATUS) kind = WORD_STATUS;
        else                              kind = WORD_NONE;
    end

    assign ridx = reg_addr[RIDX_W-1:0];

    // Route word storage, written when its address is strobed.
    generate
        for (genvar r = 0; r < ROUTE_REGS; r++) begin : g_route
            always_ff @(posedge clk) begin
                if (!rst_n)
                    route_q[r] <= '0;
                else if (reg_we && kind == WORD_ROUTE && ridx == RIDX_W'(r))
                    route_q[r] <= reg_wdata;
            end
            assign route_flat[r*DATA_W +: DATA_W] = route_q[r];
        end
    endgenerate

    // Mask word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (reg_we && kind == WORD_MASK)
            mask_q <= reg_wdata;
    end

    assign src_en = mask_q;

    // Read data selection.
    always_comb begin
        case (kind)
            WORD_ROUTE:  reg_rdata = route_q[ridx];
            WORD_MASK:   reg_rdata = mask_q;
            WORD_STATUS: reg_rdata = src_irq;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_router_fanin.sv
// Module: irq_router_fanin
// Combinational routing core: for every output line, ORs together the
// enabled, asserted sources whose route code equals line index + 1.
// Code 0 matches no line. Assumes route_flat packs source i at bits
// [i*FIELD_W +: FIELD_W].
module irq_router_fanin #(
    parameter int NUM_SRC = 32,
    parameter int FIELD_W = 4,
    parameter int NUM_OUT = 15
) (
    input  logic [NUM_SRC-1:0]          src_irq,
    input  logic [NUM_SRC-1:0]          src_en,
    input  logic [NUM_SRC*FIELD_W-1:0]  route_flat,
    output logic [NUM_OUT-1:0]          out_hit
);

    logic [NUM_SRC-1:0] live;

    // Sources that may contribute at all.
    assign live = src_irq & src_en;

    generate
        for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
            localparam logic [FIELD_W-1:0] CODE = FIELD_W'(o + 1);
            logic [NUM_SRC-1:0] sel;
            for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
                // Source i selects this line.
                assign sel[i] = live[i] & (route_flat[i*FIELD_W +: FIELD_W] == CODE);
            end
            // Line is the OR of its selected sources.
            assign out_hit[o] = |sel;
        end
    endgenerate

endmodule

// File: rtl/irq_router.sv
// Module: irq_router (top)
// Interrupt routing multiplexer. Sources pass through a per-source mask
// and a 4-bit route code onto up to 15 registered output lines; lines
// 0..CPU_LINES-1 are also wired onto a CPU bus starting at CPU_BASE.
// Assumes DATA_W sources, one mask bit each, and a synchronous
// active-low reset.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int FIELD_W   = DEF_FIELD_W,
    parameter int CPU_BUS_W = DEF_CPU_BUS_W,
    parameter int CPU_BASE  = DEF_CPU_BASE,
    parameter int CPU_LINES = DEF_CPU_LINES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DATA_W-1:0]           src_irq,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic                        reg_we,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    output logic [(1<<FIELD_W)-2:0]     out_line,
    output logic [CPU_BUS_W-1:0]        cpu_irq
);

    localparam int NUM_SRC    = DATA_W;
    localparam int NUM_OUT    = (1 << FIELD_W) - 1;
    localparam int ROUTE_REGS = (NUM_SRC * FIELD_W) / DATA_W;

    logic [ROUTE_REGS*DATA_W-1:0] route_w;
    logic [NUM_SRC-1:0]           mask_w;
    logic [NUM_OUT-1:0]           hit_w;
    logic [NUM_OUT-1:0]           out_q;

    irq_router_regs #(
        .DATA_W     (DATA_W),
        .ROUTE_REGS (ROUTE_REGS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_irq    (src_irq),
        .reg_addr   (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .route_flat (route_w),
        .src_en     (mask_w)
    );

    irq_router_fanin #(
        .NUM_SRC    (NUM_SRC),
        .FIELD_W    (FIELD_W),
        .NUM_OUT    (NUM_OUT)
    ) u_fanin (
        .src_irq    (src_irq),
        .src_en     (mask_w),
        .route_flat (route_w),
        .out_hit    (hit_w)
    );

    // Output register: one cycle from inputs or routing to the lines.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= hit_w;
    end

    assign out_line = out_q;

    // Fixed wiring of the low output lines onto the CPU bus.
    generate
        for (genvar k = 0; k < CPU_BUS_W; k++) begin : g_cpu
            if (k >= CPU_BASE && k < CPU_BASE + CPU_LINES && (k - CPU_BASE) < NUM_OUT) begin : g_wired
                assign cpu_irq[k] = out_q[k - CPU_BASE];
            end else begin : g_tied
                assign cpu_irq[k] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/irq_router_chk.sv
// Module: irq_router_chk
// Assertion checker for irq_router, attached by bind. Holds its own
// reference of the routing function and compares it with the registered
// outputs one cycle later. Assumes the default 3-bit address map.
module irq_router_chk #(
    parameter int DATA_W    = 32,
    parameter int FIELD_W   = 4,
    parameter int CPU_BUS_W = 8,
    parameter int CPU_BASE  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DATA_W-1:0]             src_irq,
    input  logic [2:0]                    reg_addr,
    input  logic [DATA_W-1:0]             reg_rdata,
    input  logic [(1<<FIELD_W)-2:0]       out_line,
    input  logic [CPU_BUS_W-1:0]          cpu_irq,
    input  logic [DATA_W*FIELD_W-1:0]     route,
    input  logic [DATA_W-1:0]             mask
);

    localparam int NUM_OUT = (1 << FIELD_W) - 1;

    logic [NUM_OUT-1:0] ref_c;

    // Reference: line o is set when some live source carries code o+1.
    always_comb begin
        ref_c = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (src_irq[i] && mask[i] && route[i*FIELD_W +: FIELD_W] != '0)
                ref_c[int'(route[i*FIELD_W +: FIELD_W]) - 1] = 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_line == '0 && route == '0 && mask == '0)); // R1

    AST_ROUTE_REF: assert property (@(posedge clk) disable iff (!rst_n)
        out_line == $past(ref_c)); // R5

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_irq & mask) == '0) |-> (out_line == '0)); // R6

    AST_CPU_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq[CPU_BASE-1:0] == '0); // R7

    AST_CPU_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq[CPU_BUS_W-1:CPU_BASE] == out_line[CPU_BUS_W-CPU_BASE-1:0]); // R7

    AST_STATUS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd5) |-> (reg_rdata == src_irq)); // R8

    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > 3'd5) |-> (reg_rdata == '0)); // R10

endmodule

bind irq_router irq_router_chk #(
    .DATA_W    (DATA_W),
    .FIELD_W   (FIELD_W),
    .CPU_BUS_W (CPU_BUS_W),
    .CPU_BASE  (CPU_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_irq   (src_irq),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .out_line  (out_line),
    .cpu_irq   (cpu_irq),
    .route     (route_w),
    .mask      (mask_w)
);

// File: tb/irq_router_tb.sv
// Bench for irq_router: exhaustive source-by-code sweep, mask sweep,
// register readback and pseudo-random routing against an arithmetic model.
module irq_router_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_irq = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [14:0] out_line;
    logic [7:0]  cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] route_m [4];
    logic [31:0] mask_m;
    logic [14:0] exp_cur;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_router u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_irq   (src_irq),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .out_line  (out_line),
        .cpu_irq   (cpu_irq)
    );

    // Arithmetic model: code v of a live source sets line v-1.
    function automatic logic [14:0] model(input logic [31:0] s);
        logic [14:0] r = '0;
        for (int i = 0; i < 32; i++) begin
            logic [3:0] c = route_m[i/8][(i%8)*4 +: 4];
            if (s[i] && mask_m[i] && c != 4'd0) r[c - 4'd1] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [7:0] cpu_of(input logic [14:0] o);
        return {o[5:0], 2'b00};
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
        if (a < 3'd4) route_m[a[1:0]] = d;
        else if (a == 3'd4) mask_m = d;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1 check(req, reg_rdata, exp);
    endtask

    // Let outputs catch up with register writes.
    task automatic settle();
        @(posedge clk); #1;
        exp_cur = model(src_irq);
    endtask

    // Apply a source pattern, check no early change, then the new outputs.
    task automatic apply(input logic [31:0] s, input string req);
        @(negedge clk);
        src_irq = s;
        #1 check("R9 early", {17'd0, out_line}, {17'd0, exp_cur});
        @(posedge clk); #1;
        exp_cur = model(s);
        check(req, {17'd0, out_line}, {17'd0, exp_cur});
        check("R7", {24'd0, cpu_irq}, {24'd0, cpu_of(exp_cur)});
    endtask

    initial begin
        for (int r = 0; r < 4; r++) route_m[r] = '0;
        mask_m = '0;
        exp_cur = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 5; a++) rd(3'(a), 32'd0, "R1 reg");
        check("R1 out", {17'd0, out_line}, 32'd0);
        check("R1 cpu", {24'd0, cpu_irq}, 32'd0);

        // R2: readback of route and mask words
        for (int a = 0; a < 5; a++) begin
            logic [31:0] v = 32'hA5C3_0F00 ^ (32'h1111_1111 * a);
            wr(3'(a), v);
        end
        for (int a = 0; a < 5; a++) rd(3'(a), (a < 4) ? route_m[a] : mask_m, "R2 readback");

        // R8 / R10: status write ignored, holes read zero and ignore writes
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'hDEAD_BEEF);
        wr(3'd7, 32'h1234_5678);
        for (int a = 0; a < 5; a++) rd(3'(a), (a < 4) ? route_m[a] : mask_m, "R10 no write effect");
        rd(3'd6, 32'd0, "R10 hole read");
        rd(3'd7, 32'd0, "R10 hole read");
        src_irq = 32'h0F0F_3C3C;
        rd(3'd5, 32'h0F0F_3C3C, "R8 status raw");
        src_irq = 32'h8000_0001;
        rd(3'd5, 32'h8000_0001, "R8 status raw");

        // Clear routing, enable all sources
        for (int a = 0; a < 4; a++) wr(3'(a), 32'd0);
        wr(3'd4, 32'hFFFF_FFFF);
        src_irq = '0;
        settle();

        // R2 R3 R4 R7: every source against every code
        for (int i = 0; i < 32; i++) begin
            for (int c = 0; c < 16; c++) begin
                logic [31:0] w = '0;
                w[(i%8)*4 +: 4] = 4'(c);
                wr(3'(i/8), w);
                src_irq = '0;
                settle();
                apply(32'd1 << i, (c == 0) ? "R3 parked" : "R4 code to line");
                if (c != 0)
                    check("R4 one-hot", {17'd0, out_line}, 32'd1 << (c - 1));
                else
                    check("R3 no line", {17'd0, out_line}, 32'd0);
                if (c >= 1 && c <= 6)
                    check("R7 cpu line", {24'd0, cpu_irq}, 32'd1 << (c + 1));
                else
                    check("R7 no cpu", {24'd0, cpu_irq}, 32'd0);
            end
            wr(3'(i/8), 32'd0);
        end

        // R6: each source masked off while routed to line 2
        for (int r = 0; r < 4; r++) wr(3'(r), 32'h3333_3333);
        for (int i = 0; i < 32; i++) begin
            wr(3'd4, ~(32'd1 << i));
            src_irq = '0;
            settle();
            apply(32'd1 << i, "R6 masked");
            check("R6 masked quiet", {17'd0, out_line}, 32'd0);
        end
        wr(3'd4, 32'hFFFF_FFFF);
        settle();
        apply(32'hFFFF_FFFF, "R6 enabled");

        // R5: random masks and sources with run-time rerouting
        for (int round = 0; round < 16; round++) begin
            for (int r = 0; r < 4; r++) begin
                lfsr = next_rand(lfsr);
                wr(3'(r), lfsr);
            end
            lfsr = next_rand(lfsr);
            wr(3'd4, lfsr | 32'h0101_0101);
            settle();
            for (int k = 0; k < 12; k++) begin
                lfsr = next_rand(lfsr);
                apply(lfsr & next_rand(lfsr ^ 32'h5555_AAAA), "R5 or-merge");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule